// File: doc/BRIEF.md
# Quad Byte SIMD Multiply-Accumulate Unit

This execution unit serves a packed SIMD extension. Each accepted instruction word names two source registers and two destination registers in a 16-entry register file held inside the block. The unit splits both sources into four bytes and forms four 8x8 products, one per byte lane. Each product is cut to 16 bits. In the multiply-only group the products are packed directly into the destinations. In the accumulate group each product is added to, or subtracted from, the matching 16-bit half of the old destination contents.

Each group has two variants. In the unsigned variant both bytes are zero-extended. In the signed-by-unsigned variant only the first source's bytes are sign-extended. Any other variant code inside the two groups is reserved: the unit raises a one-cycle flag and changes nothing. A plain load port fills registers, and a read port shows any register, so operands can be set up and results observed.

Top module: `qbmac_unit`

## Requirements
- R1: An instruction is taken when `instr_valid` is high. The fields are: major opcode bits 5:0, first destination A bits 9:6, first source B bits 13:10, second source C bits 17:14, second destination D bits 21:18, variant bits 23:22 and add/subtract pattern bits 25:24. Major 0x38 is multiply-only and 0x3A is accumulate. Variant 00 is unsigned and 10 is signed-by-unsigned.
- R2: Under major 0x38 or 0x3A, a variant of 01 or 11 sets `reserved_o` high for exactly the cycle after the clock edge that took the instruction, and no register changes.
- R3: An instruction with any other major opcode writes nothing and leaves `reserved_o` low.
- R4: Lane i (i = 0..3) multiplies byte i of B (bits 8i+7:8i) by byte i of C, and keeps the low 16 bits of the product. The unsigned variant zero-extends both bytes.
- R5: The signed-by-unsigned variant sign-extends the bytes of B only. The bytes of C stay unsigned.
- R6: In multiply-only form, D receives lane 0 in bits 15:0 and lane 1 in bits 31:16. A receives lane 2 in bits 15:0 and lane 3 in bits 31:16.
- R7: In accumulate form, lanes 0 and 1 combine with the low and high halves of the old D value. Lanes 2 and 3 combine with the halves of the old A value. Each half wraps modulo 2^16, and no carry passes between halves.
- R8: In accumulate form, pattern bit 24 set makes lanes 0 and 1 compute old half minus product. Pattern bit 25 set does the same for lanes 2 and 3. A clear bit means old half plus product.
- R9: Both destinations are written on the same clock edge, from source and old values read before that edge. When A and D name the same register, the A result is kept.
- R10: Register 0 always reads as zero and ignores writes from instructions and from the load port.
- R11: `ld_en` writes `ld_data` into register `ld_sel` on the clock edge. If an executing instruction writes the same register on that edge, the instruction result is kept.
- R12: After reset every register reads zero and `reserved_o` is low. `rd_data` shows register `rd_sel` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 4 | Register written by a load |
| ld_data | input | 32 | Load value |
| rd_sel | input | 4 | Register shown on rd_data |
| rd_data | output | 32 | Contents of register rd_sel |
| reserved_o | output | 1 | Reserved encoding seen on the last edge |

## Verification
The sweep covers every combination of major group, variant code and pattern bits. Operand bytes of all 0x80 separate sign extension from zero extension on the first source only. Bytes of all 0xFF show truncation and the wrap of accumulated halves. Random values show lane independence. Register selections are random, so sources, destinations and register 0 overlap often. Directed cases force A equal to D, a load that collides with a destination, and a foreign major opcode, which tell apart the write priorities and the ignore paths.

// File: rtl/qbmac_pkg.sv
package qbmac_pkg;
  localparam int DATA_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int HALF_W  = 2 * BYTE_W;
  localparam int LANES   = DATA_W / BYTE_W;
  localparam int LPR     = DATA_W / HALF_W;   // lanes packed per register
  localparam int SEL_W   = 4;
  localparam int OPC_W   = 6;

  localparam logic [OPC_W-1:0] OPC_MUL = 6'h38;
  localparam logic [OPC_W-1:0] OPC_MAC = 6'h3A;
  localparam logic [1:0] VAR_UNS = 2'b00;
  localparam logic [1:0] VAR_SU  = 2'b10;

  typedef struct packed {
    logic             hit;      // major opcode belongs to this unit
    logic             illegal;  // variant code is reserved
    logic             acc;      // accumulate group
    logic             su;       // signed-by-unsigned variant
    logic [1:0]       pat;      // add/subtract pattern
    logic [SEL_W-1:0] dst_a;
    logic [SEL_W-1:0] src_b;
    logic [SEL_W-1:0] src_c;
    logic [SEL_W-1:0] dst_d;
  } dec_t;

  // Byte product truncated to one half; only x may be sign extended.
  function automatic logic [HALF_W-1:0] lane_mul(input logic [BYTE_W-1:0] x,
                                                 input logic [BYTE_W-1:0] y,
                                                 input logic sx);
    logic [HALF_W-1:0] xe, ye;
    xe = sx ? {{BYTE_W{x[BYTE_W-1]}}, x} : {{BYTE_W{1'b0}}, x};
    ye = {{BYTE_W{1'b0}}, y};
    return xe * ye;
  endfunction

  // Wrapping combine of an old half with a product.
  function automatic logic [HALF_W-1:0] lane_acc(input logic [HALF_W-1:0] old,
                                                 input logic [HALF_W-1:0] prod,
                                                 input logic sub);
    return sub ? old - prod : old + prod;
  endfunction
endpackage

// File: rtl/qbmac_decode.sv
module qbmac_decode
  import qbmac_pkg::*;
(
  input  logic [DATA_W-1:0] instr,
  output dec_t              dec
);
  logic [OPC_W-1:0] opc;
  logic [1:0]       vsel;

  assign opc  = instr[OPC_W-1:0];
  assign vsel = instr[23:22];

  always_comb begin
    dec.hit     = (opc == OPC_MUL) || (opc == OPC_MAC);
    dec.illegal = (vsel != VAR_UNS) && (vsel != VAR_SU);
    dec.acc     = (opc == OPC_MAC);
    dec.su      = (vsel == VAR_SU);
    dec.pat     = instr[25:24];
    dec.dst_a   = instr[9:6];
    dec.src_b   = instr[13:10];
    dec.src_c   = instr[17:14];
    dec.dst_d   = instr[21:18];
  end
endmodule

// File: rtl/qbmac_lanes.sv
module qbmac_lanes
  import qbmac_pkg::*;
(
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] src_c,
  input  logic [DATA_W-1:0] old_lo,   // old second-destination value
  input  logic [DATA_W-1:0] old_hi,   // old first-destination value
  input  logic              su,
  input  logic              acc,
  input  logic [1:0]        pat,
  output logic [DATA_W-1:0] res_lo,
  output logic [DATA_W-1:0] res_hi
);
  logic [LANES*HALF_W-1:0] lane_res;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [HALF_W-1:0] prod;
    logic [HALF_W-1:0] old_half;
    logic              sub;

    assign prod = lane_mul(src_b[i*BYTE_W +: BYTE_W], src_c[i*BYTE_W +: BYTE_W], su);

    if (i < LPR) begin : g_low
      assign old_half = old_lo[(i % LPR)*HALF_W +: HALF_W];
      assign sub      = pat[0];
    end else begin : g_high
      assign old_half = old_hi[(i % LPR)*HALF_W +: HALF_W];
      assign sub      = pat[1];
    end

    assign lane_res[i*HALF_W +: HALF_W] = acc ? lane_acc(old_half, prod, sub) : prod;
  end

  assign res_lo = lane_res[DATA_W-1:0];
  assign res_hi = lane_res[2*DATA_W-1:DATA_W];
endmodule

// File: rtl/qbmac_regfile.sv
module qbmac_regfile
  import qbmac_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel_a,
  input  logic [SEL_W-1:0]  sel_b,
  input  logic [SEL_W-1:0]  sel_c,
  input  logic [SEL_W-1:0]  sel_d,
  input  logic [SEL_W-1:0]  sel_r,
  output logic [DATA_W-1:0] dat_a,
  output logic [DATA_W-1:0] dat_b,
  output logic [DATA_W-1:0] dat_c,
  output logic [DATA_W-1:0] dat_d,
  output logic [DATA_W-1:0] dat_r,
  input  logic              we_hi,    // first destination, highest priority
  input  logic [SEL_W-1:0]  wsel_hi,
  input  logic [DATA_W-1:0] wdat_hi,
  input  logic              we_lo,    // second destination
  input  logic [SEL_W-1:0]  wsel_lo,
  input  logic [DATA_W-1:0] wdat_lo,
  input  logic              we_ld,    // load port, lowest priority
  input  logic [SEL_W-1:0]  wsel_ld,
  input  logic [DATA_W-1:0] wdat_ld
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    if (r == 0) begin : g_zero
      assign regs[r] = '0;
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               regs[r] <= '0;
        else if (we_hi && wsel_hi == SEL_W'(r))   regs[r] <= wdat_hi;
        else if (we_lo && wsel_lo == SEL_W'(r))   regs[r] <= wdat_lo;
        else if (we_ld && wsel_ld == SEL_W'(r))   regs[r] <= wdat_ld;
      end
    end
  end

  assign dat_a = regs[sel_a];
  assign dat_b = regs[sel_b];
  assign dat_c = regs[sel_c];
  assign dat_d = regs[sel_d];
  assign dat_r = regs[sel_r];
endmodule

// File: rtl/qbmac_unit.sv
module qbmac_unit
  import qbmac_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [31:0]       instr,
  input  logic              ld_en,
  input  logic [3:0]        ld_sel,
  input  logic [31:0]       ld_data,
  input  logic [3:0]        rd_sel,
  output logic [31:0]       rd_data,
  output logic              reserved_o
);
  dec_t              dec;
  logic              exec_en;   // legal instruction writes this edge
  logic              bad_en;    // reserved encoding seen this cycle
  logic [DATA_W-1:0] op_a, op_b, op_c, op_d;
  logic [DATA_W-1:0] res_lo, res_hi;
  logic              reserved_q;

  qbmac_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  assign exec_en = instr_valid && dec.hit && !dec.illegal;
  assign bad_en  = instr_valid && dec.hit && dec.illegal;

  qbmac_regfile #(.NREG(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_a   (dec.dst_a),
    .sel_b   (dec.src_b),
    .sel_c   (dec.src_c),
    .sel_d   (dec.dst_d),
    .sel_r   (rd_sel),
    .dat_a   (op_a),
    .dat_b   (op_b),
    .dat_c   (op_c),
    .dat_d   (op_d),
    .dat_r   (rd_data),
    .we_hi   (exec_en),
    .wsel_hi (dec.dst_a),
    .wdat_hi (res_hi),
    .we_lo   (exec_en),
    .wsel_lo (dec.dst_d),
    .wdat_lo (res_lo),
    .we_ld   (ld_en),
    .wsel_ld (ld_sel),
    .wdat_ld (ld_data)
  );

  qbmac_lanes u_lanes (
    .src_b  (op_b),
    .src_c  (op_c),
    .old_lo (op_d),
    .old_hi (op_a),
    .su     (dec.su),
    .acc    (dec.acc),
    .pat    (dec.pat),
    .res_lo (res_lo),
    .res_hi (res_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reserved_q <= 1'b0;
    else        reserved_q <= bad_en;
  end

  assign reserved_o = reserved_q;
endmodule

// File: rtl/qbmac_chk.sv
module qbmac_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid,
  input logic [31:0] instr,
  input logic        ld_en,
  input logic [3:0]  rd_sel,
  input logic [31:0] rd_data,
  input logic        reserved_o,
  input logic        exec_en,
  input logic        bad_en
);
  logic grp, good_var;
  assign grp      = (instr[5:0] == 6'h38) || (instr[5:0] == 6'h3A);
  assign good_var = (instr[23:22] == 2'b00) || (instr[23:22] == 2'b10);

  a_r1_legal_executes: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && grp && good_var) |-> exec_en);

  a_r2_flag_follows_bad: assert property (@(posedge clk) disable iff (!rst_n)
    bad_en |=> reserved_o);

  a_r2_flag_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    reserved_o |-> $past(bad_en));

  a_r3_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !grp) |-> (!exec_en && !bad_en));

  a_r10_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 4'd0) |-> (rd_data == 32'd0));

  a_r12_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_en && !ld_en) |=> ((rd_sel != $past(rd_sel)) || (rd_data == $past(rd_data))));
endmodule

bind qbmac_unit qbmac_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr       (instr),
  .ld_en       (ld_en),
  .rd_sel      (rd_sel),
  .rd_data     (rd_data),
  .reserved_o  (reserved_o),
  .exec_en     (exec_en),
  .bad_en      (bad_en)
);

// File: tb/qbmac_unit_tb.sv
module qbmac_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_sel = '0;
  logic [31:0] ld_data = '0;
  logic [3:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        reserved_o;

  int checks = 0;
  int fails = 0;
  logic [31:0] mdl [16];
  logic [31:0] seed = 32'h1234_5678;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qbmac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .reserved_o(reserved_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  // Bench-side arithmetic: widen to int, multiply, keep 16 bits.
  function automatic logic [15:0] m_prod(input logic [7:0] x, input logic [7:0] y, input bit su);
    int xv, p;
    if (su) xv = int'($signed(x));
    else    xv = int'(x);
    p = xv * int'(y);
    return p[15:0];
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [1:0] vsel,
                                     input logic [1:0] pat, input logic [3:0] a,
                                     input logic [3:0] b, input logic [3:0] c,
                                     input logic [3:0] d);
    return {6'b0, pat, vsel, d, c, b, a, opc};
  endfunction

  task automatic check_all(input string req);
    for (int r = 0; r < 16; r++) begin
      rd_sel = 4'(r);
      #1;
      chk($sformatf("%s reg%0d", req, r), rd_data, mdl[r]);
    end
  endtask

  task automatic do_load(input logic [3:0] sel, input logic [31:0] data);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_data = data;
    @(negedge clk);
    ld_en = 1'b0;
    if (sel != 0) mdl[sel] = data;   // R10: load to register 0 dropped
  endtask

  // Updates the model; returns expected reserved flag and a requirement tag.
  task automatic model_exec(input logic [31:0] w, output bit rsv, output string tag);
    logic [5:0] opc; logic [1:0] vsel, pat;
    int a, b, c, d;
    bit su, acc;
    logic [15:0] lane [4];
    logic [15:0] old [4];
    logic [31:0] nd, na;
    opc = w[5:0]; vsel = w[23:22]; pat = w[25:24];
    a = w[9:6]; b = w[13:10]; c = w[17:14]; d = w[21:18];
    rsv = 1'b0;
    if (opc != 6'h38 && opc != 6'h3A) begin tag = "R3"; return; end
    if (vsel[0]) begin rsv = 1'b1; tag = "R2"; return; end
    su  = (vsel == 2'b10);
    acc = (opc == 6'h3A);
    old[0] = mdl[d][15:0]; old[1] = mdl[d][31:16];
    old[2] = mdl[a][15:0]; old[3] = mdl[a][31:16];
    for (int i = 0; i < 4; i++) begin
      lane[i] = m_prod(mdl[b][8*i +: 8], mdl[c][8*i +: 8], su);
      if (acc) begin
        if (pat[i/2]) lane[i] = old[i] - lane[i];
        else          lane[i] = old[i] + lane[i];
      end
    end
    nd = {lane[1], lane[0]};
    na = {lane[3], lane[2]};
    if (d != 0) mdl[d] = nd;
    if (a != 0) mdl[a] = na;      // R9: A result kept on alias
    tag = $sformatf("R1 %s %s R9", acc ? "R7 R8" : "R6", su ? "R5" : "R4");
  endtask

  task automatic do_exec(input logic [31:0] w, input bit with_ld,
                         input logic [3:0] lsel, input logic [31:0] ldat);
    bit rsv; string tag;
    if (with_ld && lsel != 0) mdl[lsel] = ldat;   // load applied first, instr overrides
    model_exec(w, rsv, tag);
    @(negedge clk);
    instr_valid = 1'b1; instr = w;
    if (with_ld) begin ld_en = 1'b1; ld_sel = lsel; ld_data = ldat; end
    @(negedge clk);
    instr_valid = 1'b0; ld_en = 1'b0;
    chk({tag, " reserved flag"}, {31'b0, reserved_o}, {31'b0, rsv});
    check_all(with_ld ? {tag, " R11"} : tag);
    @(negedge clk);
    chk({tag, " R2 flag one cycle"}, {31'b0, reserved_o}, 32'd0);
  endtask

  function automatic logic [31:0] operand(input int n);
    if (n == 0) return 32'h8080_8080;
    if (n == 1) return 32'hFFFF_FFFF;
    if (n == 2) return 32'h807F_FF01;
    return rnd();
  endfunction

  initial begin
    for (int r = 0; r < 16; r++) mdl[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12: reset state
    chk("R12 reserved after reset", {31'b0, reserved_o}, 32'd0);
    check_all("R12");

    // R10: load to register 0 ignored
    do_load(4'd0, 32'hDEAD_BEEF);
    check_all("R10");

    // Main sweep: both groups, all variant codes, all patterns
    for (int g = 0; g < 2; g++)
      for (int v = 0; v < 4; v++)
        for (int p = 0; p < 4; p++)
          for (int n = 0; n < 5; n++) begin
            logic [3:0] ra, rb, rc, rdd;
            ra = 4'(rnd()); rb = 4'(rnd()); rc = 4'(rnd()); rdd = 4'(rnd());
            do_load(rb, operand(n));
            do_load(rc, (n == 2) ? 32'hFF80_02FF : operand(n));
            do_load(ra, operand(n + 3));
            do_load(rdd, operand(n + 4));
            do_exec(mk(g ? 6'h3A : 6'h38, 2'(v), 2'(p), ra, rb, rc, rdd), 1'b0, 4'd0, 32'd0);
          end

    // R9: both destinations name one register
    do_load(4'd3, 32'h8081_FF7F); do_load(4'd4, 32'hFFFF_0280); do_load(4'd5, 32'h1234_ABCD);
    do_exec(mk(6'h3A, 2'b10, 2'b01, 4'd5, 4'd3, 4'd4, 4'd5), 1'b0, 4'd0, 32'd0);
    do_exec(mk(6'h38, 2'b00, 2'b00, 4'd6, 4'd3, 4'd4, 4'd6), 1'b0, 4'd0, 32'd0);

    // R10: register 0 as both destinations
    do_exec(mk(6'h3A, 2'b00, 2'b11, 4'd0, 4'd3, 4'd4, 4'd0), 1'b0, 4'd0, 32'd0);

    // R11: load collides with a destination, and one that does not
    do_exec(mk(6'h38, 2'b00, 2'b00, 4'd7, 4'd3, 4'd4, 4'd8), 1'b1, 4'd7, 32'hAAAA_5555);
    do_exec(mk(6'h38, 2'b10, 2'b00, 4'd7, 4'd3, 4'd4, 4'd8), 1'b1, 4'd9, 32'h0BAD_F00D);

    // R3: foreign major opcodes ignored
    do_exec(mk(6'h39, 2'b00, 2'b00, 4'd7, 4'd3, 4'd4, 4'd8), 1'b0, 4'd0, 32'd0);
    do_exec(mk(6'h3B, 2'b01, 2'b00, 4'd7, 4'd3, 4'd4, 4'd8), 1'b0, 4'd0, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule